// File: doc/BRIEF.md
# Bimodal Branch Direction Predictor

This block guesses, at fetch time, whether a conditional branch will be taken. It holds a small direct-mapped table of saturating counters that is addressed by word-aligned bits of the program counter. The fetch stage presents its PC and gets a taken/not-taken guess back combinationally in the same cycle. Once the branch has been executed, a later pipeline stage returns the branch PC, the real outcome and a valid strobe. The addressed counter then moves one step toward that outcome on the next clock edge.

The counter width is a build-time parameter. With one bit, each entry simply remembers the last outcome of the branches that map to it. With two bits, each entry has strong and weak states. This adds hysteresis, so one outcome that goes against a settled pattern does not flip the next guess. The index width is also a parameter and defaults to six bits, which gives 64 entries.

Top module: `bimodal_dir_pred`

## Requirements
- R1: The entry is selected by PC bits [IDX_W+1:2]. PC bits [1:0] and all bits above IDX_W+1 have no effect, so PCs that agree in bits [IDX_W+1:2] share one entry.
- R2: `pred_taken` is a combinational function of `fetch_pc` and the table contents. It reflects a change of `fetch_pc` within the same cycle.
- R3: After synchronous reset every entry predicts not-taken. In 2-bit mode every entry starts in weak not-taken, so one taken update makes it predict taken, and a not-taken update followed by a taken update leaves it predicting not-taken.
- R4: While `upd_valid` is low, no entry changes, whatever `upd_pc` and `upd_taken` carry.
- R5: In 2-bit mode the states are encoded 0 = strong not-taken, 1 = weak not-taken, 2 = weak taken, 3 = strong taken, and the upper bit gives the prediction. A taken update adds one and saturates at 3, so two taken updates in a row always leave the entry predicting taken.
- R6: In 2-bit mode a not-taken update subtracts one and saturates at 0, so two not-taken updates in a row always leave the entry predicting not-taken. A single taken update from 0 still predicts not-taken.
- R7: In 2-bit mode, one opposite outcome applied to a strong state does not change that entry's prediction.
- R8: In 1-bit mode an update sets the entry to the outcome itself. A loop branch taken three times and then not taken mispredicts twice on every pass after the first. A 2-bit table mispredicts once per pass on the same pattern.
- R9: When the fetch index and a valid update index are the same in one cycle, `pred_taken` in that cycle shows the value from before the update. The update is visible from the next cycle on.
- R10: An update changes only the entry it addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | PC_W | PC being fetched |
| pred_taken | output | 1 | Predicted direction for `fetch_pc` (1 = taken) |
| upd_valid | input | 1 | Resolved branch outcome is present this cycle |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Resolved outcome (1 = taken) |

## Verification
The fetch-side lookup and the resolve-side counter step can address the same entry in one cycle. The bench provokes this by driving `fetch_pc` and a valid update with one PC before the same edge. It samples the guess ahead of that edge and expects the old counter value. It then expects the stepped value one cycle later. The lookup and the step are also exercised on different entries and on aliasing PCs, to show that one never leaks into the other.

// File: rtl/bpred_pkg.sv
package bpred_pkg;

    // Two-bit counter states; the upper bit is the direction guess.
    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'd0,
        CTR_WEAK_NT   = 2'd1,
        CTR_WEAK_TK   = 2'd2,
        CTR_STRONG_TK = 2'd3
    } ctr2_e;

    // Resolved branch outcome as it arrives from the execute side.
    typedef struct packed {
        logic valid;
        logic taken;
    } outcome_t;

    // One saturating step of a two-bit counter.
    function automatic logic [1:0] ctr2_step(input logic [1:0] cur, input logic taken);
        ctr2_e s;
        ctr2_e n;
        s = ctr2_e'(cur);
        n = s;
        if (taken) begin
            case (s)
                CTR_STRONG_NT: n = CTR_WEAK_NT;
                CTR_WEAK_NT:   n = CTR_WEAK_TK;
                CTR_WEAK_TK:   n = CTR_STRONG_TK;
                default:       n = CTR_STRONG_TK;
            endcase
        end else begin
            case (s)
                CTR_STRONG_TK: n = CTR_WEAK_TK;
                CTR_WEAK_TK:   n = CTR_WEAK_NT;
                CTR_WEAK_NT:   n = CTR_STRONG_NT;
                default:       n = CTR_STRONG_NT;
            endcase
        end
        return logic'(n[1]) ? {1'b1, n[0]} : {1'b0, n[0]};
    endfunction

    // Reset value of an entry for a given counter width.
    function automatic logic [1:0] ctr_init(input int width);
        return (width == 2) ? 2'(CTR_WEAK_NT) : 2'b00;
    endfunction

endpackage

// File: rtl/bpred_index.sv
module bpred_index #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);
    localparam int LO = 2;
    localparam int HI = IDX_W + 1;

    assign idx = pc[HI:LO];

    logic unused_pc_bits;
    assign unused_pc_bits = ^{pc[LO-1:0], pc[PC_W-1:HI+1]};
endmodule

// File: rtl/bpred_ctr_step.sv
module bpred_ctr_step
    import bpred_pkg::*;
#(
    parameter int CTR_W = 2
) (
    input  logic [CTR_W-1:0] cur,
    input  logic             taken,
    output logic [CTR_W-1:0] nxt
);
    generate
        if (CTR_W == 1) begin : g_last_outcome
            assign nxt = taken;
            logic unused_cur;
            assign unused_cur = cur[0];
        end else begin : g_saturating
            assign nxt = CTR_W'(ctr2_step(cur[1:0], taken));
        end
    endgenerate
endmodule

// File: rtl/bpred_table.sv
module bpred_table #(
    parameter int              IDX_W = 6,
    parameter int              CTR_W = 2,
    parameter logic [CTR_W-1:0] INIT = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CTR_W-1:0] rd_ctr,
    input  logic [IDX_W-1:0] mod_idx,
    output logic [CTR_W-1:0] mod_cur,
    input  logic             wr_en,
    input  logic [CTR_W-1:0] wr_ctr
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [CTR_W-1:0] ctr_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ctr_q[i] <= INIT;
            end
        end else if (wr_en) begin
            ctr_q[mod_idx] <= wr_ctr;
        end
    end

    // Read ports see the stored value, so a same-cycle write is not forwarded.
    assign rd_ctr  = ctr_q[rd_idx];
    assign mod_cur = ctr_q[mod_idx];
endmodule

// File: rtl/bimodal_dir_pred.sv
module bimodal_dir_pred
    import bpred_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6,
    parameter int CTR_W = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);
    localparam logic [CTR_W-1:0] INIT_CTR = CTR_W'(ctr_init(CTR_W));

    logic [IDX_W-1:0] fetch_idx;
    logic [IDX_W-1:0] upd_idx;
    logic [CTR_W-1:0] fetch_ctr;
    logic [CTR_W-1:0] upd_cur;
    logic [CTR_W-1:0] upd_nxt;
    outcome_t         res;

    assign res.valid = upd_valid;
    assign res.taken = upd_taken;

    bpred_index #(.PC_W(PC_W), .IDX_W(IDX_W)) fetch_ix_i (
        .pc  (fetch_pc),
        .idx (fetch_idx)
    );

    bpred_index #(.PC_W(PC_W), .IDX_W(IDX_W)) upd_ix_i (
        .pc  (upd_pc),
        .idx (upd_idx)
    );

    bpred_table #(.IDX_W(IDX_W), .CTR_W(CTR_W), .INIT(INIT_CTR)) table_i (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (fetch_idx),
        .rd_ctr  (fetch_ctr),
        .mod_idx (upd_idx),
        .mod_cur (upd_cur),
        .wr_en   (res.valid),
        .wr_ctr  (upd_nxt)
    );

    bpred_ctr_step #(.CTR_W(CTR_W)) step_i (
        .cur   (upd_cur),
        .taken (res.taken),
        .nxt   (upd_nxt)
    );

    assign pred_taken = fetch_ctr[CTR_W-1];

    generate
        if (CTR_W > 1) begin : g_strength_bits
            logic unused_strength;
            assign unused_strength = ^fetch_ctr[CTR_W-2:0];
        end
    endgenerate
endmodule

// File: rtl/bpred_dir_chk.sv
module bpred_dir_chk #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6,
    parameter int CTR_W = 2
) (
    input logic            clk,
    input logic            rst,
    input logic [PC_W-1:0] fetch_pc,
    input logic            pred_taken,
    input logic            upd_valid,
    input logic [PC_W-1:0] upd_pc,
    input logic            upd_taken
);
    logic [IDX_W-1:0] fidx;
    logic [IDX_W-1:0] uidx;
    assign fidx = fetch_pc[IDX_W+1:2];
    assign uidx = upd_pc[IDX_W+1:2];

    logic unused_chk_bits;
    assign unused_chk_bits = ^{fetch_pc[1:0], fetch_pc[PC_W-1:IDX_W+2],
                               upd_pc[1:0], upd_pc[PC_W-1:IDX_W+2]};

    logic             live;
    logic             rst_q;
    logic             prv_tk;
    logic             prv_nt;
    logic             updv_q;
    logic             pred_q;
    logic [IDX_W-1:0] uidx_q;
    logic [IDX_W-1:0] fidx_q;

    always_ff @(posedge clk) begin
        rst_q  <= rst;
        uidx_q <= uidx;
        fidx_q <= fidx;
        pred_q <= pred_taken;
        if (rst) begin
            live   <= 1'b0;
            prv_tk <= 1'b0;
            prv_nt <= 1'b0;
            updv_q <= 1'b0;
        end else begin
            live   <= 1'b1;
            prv_tk <= upd_valid && upd_taken;
            prv_nt <= upd_valid && !upd_taken;
            updv_q <= upd_valid;
        end
    end

    // R3: first cycle out of reset predicts not-taken for any PC
    p_reset_not_taken_r3: assert property (@(posedge clk) disable iff (rst)
        (rst_q === 1'b1) |-> !pred_taken);

    // R5: two taken updates in a row to one entry give a taken guess
    p_two_taken_r5: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && upd_taken && prv_tk && uidx_q == uidx)
        |=> (fidx != $past(uidx) || pred_taken));

    // R6: two not-taken updates in a row to one entry give a not-taken guess
    p_two_not_taken_r6: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_taken && prv_nt && uidx_q == uidx)
        |=> (fidx != $past(uidx) || !pred_taken));

    // R4 / R9 / R10: a guess changes only after an update to that entry
    p_hold_without_update_r4: assert property (@(posedge clk) disable iff (rst)
        (live && fidx == fidx_q && !(updv_q && uidx_q == fidx))
        |-> (pred_taken == pred_q));

    generate
        if (CTR_W == 1) begin : g_one_bit
            // R8: one-bit entry holds the last outcome written
            p_last_outcome_r8: assert property (@(posedge clk) disable iff (rst)
                upd_valid |=> (fidx != $past(uidx) || pred_taken == $past(upd_taken)));
        end
    endgenerate
endmodule

bind bimodal_dir_pred bpred_dir_chk #(
    .PC_W  (PC_W),
    .IDX_W (IDX_W),
    .CTR_W (CTR_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .fetch_pc   (fetch_pc),
    .pred_taken (pred_taken),
    .upd_valid  (upd_valid),
    .upd_pc     (upd_pc),
    .upd_taken  (upd_taken)
);

// File: tb/bimodal_dir_pred_tb_top.sv
module bimodal_dir_pred_tb_top;
    localparam int PC_W  = 32;
    localparam int IDX_W = 6;
    localparam int NENT  = 1 << IDX_W;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [PC_W-1:0] fetch_pc = '0;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;
    logic            pred2;
    logic            pred1;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int m2 [NENT];
    int m1 [NENT];

    always #2 clk = ~clk;

    bimodal_dir_pred #(.PC_W(PC_W), .IDX_W(IDX_W), .CTR_W(2)) dut_i (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_taken(pred2),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
    );

    bimodal_dir_pred #(.PC_W(PC_W), .IDX_W(IDX_W), .CTR_W(1)) dut_one_i (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .pred_taken(pred1),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
    );

    function automatic int ix(input logic [PC_W-1:0] pc);
        return int'(pc[IDX_W+1:2]);
    endfunction

    function automatic logic mp2(input logic [PC_W-1:0] pc);
        return m2[ix(pc)] >= 2;
    endfunction

    function automatic logic mp1(input logic [PC_W-1:0] pc);
        return m1[ix(pc)] != 0;
    endfunction

    task automatic model_step(input logic [PC_W-1:0] pc, input logic t);
        int k;
        k = ix(pc);
        if (t) m2[k] = (m2[k] == 3) ? 3 : m2[k] + 1;
        else   m2[k] = (m2[k] == 0) ? 0 : m2[k] - 1;
        m1[k] = t ? 1 : 0;
    endtask

    task automatic expect_bit(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    task automatic expect_int(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic upd(input logic [PC_W-1:0] pc, input logic t);
        @(negedge clk);
        upd_valid = 1'b1;
        upd_pc    = pc;
        upd_taken = t;
        @(posedge clk);
        model_step(pc, t);
        #1 upd_valid = 1'b0;
    endtask

    task automatic chk(input logic [PC_W-1:0] pc, input logic e2, input logic e1, input string rq);
        @(negedge clk);
        fetch_pc = pc;
        #1;
        expect_bit(pred2, e2, {rq, " two-bit"});
        expect_bit(pred1, e1, {rq, " one-bit"});
        expect_bit(pred2, mp2(pc), {rq, " two-bit vs model"});
        expect_bit(pred1, mp1(pc), {rq, " one-bit vs model"});
    endtask

    task automatic t_reset;
        for (int i = 0; i < NENT; i++) begin
            m2[i] = 1;
            m1[i] = 0;
        end
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        chk(32'h0000_0000, 1'b0, 1'b0, "R3 reset entry 0");
        chk(32'h0000_003c, 1'b0, 1'b0, "R3 reset entry 15");
        chk(32'h0000_00fc, 1'b0, 1'b0, "R3 reset entry 63");
    endtask

    task automatic t_weak_start;
        upd(32'h10, 1'b0);
        upd(32'h10, 1'b1);
        chk(32'h10, 1'b0, 1'b1, "R3 weak start NT then T");
        upd(32'h14, 1'b1);
        chk(32'h14, 1'b1, 1'b1, "R3 weak start single T");
    endtask

    task automatic t_saturate_up;
        for (int i = 0; i < 4; i++) upd(32'h20, 1'b1);
        chk(32'h20, 1'b1, 1'b1, "R5 saturate taken");
        upd(32'h20, 1'b0);
        chk(32'h20, 1'b1, 1'b0, "R7 strong taken survives one NT / R8 last outcome");
        upd(32'h20, 1'b0);
        chk(32'h20, 1'b0, 1'b0, "R6 second NT flips");
    endtask

    task automatic t_saturate_down;
        for (int i = 0; i < 4; i++) upd(32'h30, 1'b0);
        chk(32'h30, 1'b0, 1'b0, "R6 saturate not-taken");
        upd(32'h30, 1'b1);
        chk(32'h30, 1'b0, 1'b1, "R7 strong NT survives one T");
        upd(32'h30, 1'b1);
        chk(32'h30, 1'b1, 1'b1, "R5 second T flips");
    endtask

    task automatic t_alias;
        upd(32'h0000_0203, 1'b1);
        upd(32'h0000_0203, 1'b1);
        chk(32'h0000_0100, 1'b1, 1'b1, "R1 alias shares entry");
        chk(32'h8000_0002, 1'b1, 1'b1, "R1 high and offset bits ignored");
        chk(32'h0000_0104, 1'b0, 1'b0, "R10 neighbour entry untouched");
    endtask

    task automatic t_no_update;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            upd_valid = 1'b0;
            upd_pc    = 32'h40;
            upd_taken = 1'(i % 2 == 0);
        end
        chk(32'h40, 1'b0, 1'b0, "R4 no change without valid");
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        fetch_pc  = 32'h50;
        upd_valid = 1'b1;
        upd_pc    = 32'h50;
        upd_taken = 1'b1;
        #1;
        expect_bit(pred2, 1'b0, "R9 two-bit old value on collision");
        expect_bit(pred1, 1'b0, "R9 one-bit old value on collision");
        @(posedge clk);
        model_step(32'h50, 1'b1);
        #1 upd_valid = 1'b0;
        #1;
        expect_bit(pred2, 1'b1, "R9 two-bit new value next cycle");
        expect_bit(pred1, 1'b1, "R9 one-bit new value next cycle");
    endtask

    task automatic t_comb_read;
        @(negedge clk);
        fetch_pc = 32'h100;
        #0.5;
        expect_bit(pred2, 1'b1, "R2 same-cycle read A");
        fetch_pc = 32'h104;
        #0.5;
        expect_bit(pred2, 1'b0, "R2 same-cycle read B");
        expect_bit(pred1, 1'b0, "R2 same-cycle read B one-bit");
    endtask

    task automatic t_loop;
        int miss2;
        int miss1;
        logic t;
        miss2 = 0;
        miss1 = 0;
        for (int p = 0; p < 4; p++) begin
            for (int it = 0; it < 4; it++) begin
                t = (it < 3);
                @(negedge clk);
                fetch_pc = 32'h60;
                #1;
                expect_bit(pred2, mp2(32'h60), "R5 loop two-bit vs model");
                expect_bit(pred1, mp1(32'h60), "R8 loop one-bit vs model");
                if (p > 0) begin
                    if (pred2 !== t) miss2++;
                    if (pred1 !== t) miss1++;
                end
                upd(32'h60, t);
            end
        end
        expect_int(miss1, 6, "R8 one-bit loop mispredicts (3 passes)");
        expect_int(miss2, 3, "R8 two-bit loop mispredicts (3 passes)");
    endtask

    initial begin
        t_reset();
        t_weak_start();
        t_saturate_up();
        t_saturate_down();
        t_alias();
        t_no_update();
        t_same_cycle();
        t_comb_read();
        t_loop();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog all requirements actual=timeout expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule